// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM. The RAM is 16 bits wide, has 128K words, and has active-low chip, output and write enables plus one active-low enable per byte lane. Each accepted request turns into a strobe sequence that the block builds from clock-cycle counts:

- **Write:** an address/data setup phase, a byte-enable pulse, then a hold phase.
- **Read:** an address phase with the output enable still high, then an access wait with the output enable low. The last cycle of the wait samples the data bus.

The data bus is split into `mem_dq_o`, `mem_dq_oe_o` and `mem_dq_i`, so the pad cell at chip level does the tristate. The controller drives the bus only while the write enable is low.

The requester uses a valid/ready handshake. Read data comes back with a one-cycle valid pulse. Mask bit 1 selects the upper lane [15:8] and bit 0 selects the lower lane [7:0]. A write that arrives in the last hold cycle of another write keeps the write enable low. The byte enables alone then frame each word of the burst. A write with an empty mask is taken without any strobe.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever no access is running, chip, output and write enables and both byte enables are high (1), the bus is not driven and `req_ready_o` is high.
- R2: A write with a nonzero mask holds write enable low and drives the bus for WR_SETUP+WR_PULSE+WR_HOLD cycles. The byte enables of the masked lanes go low for WR_PULSE cycles in the middle. Only lanes whose mask bit is 1 change in memory (bit 1 = [15:8], bit 0 = [7:0]).
- R3: `rsp_valid_o` rises exactly RD_WAIT+1 clock edges after the edge that accepts a read. `rsp_rdata_o` carries the selected lanes, and lanes whose mask bit is 0 read as zero.
- R4: Output enable and write enable are never low together. The bus is never driven while output enable is low. Output enable falls only after a cycle in which the bus was released and write enable was high.
- R5: Chip enable is low whenever output enable or write enable is low, and it returns high when the access completes.
- R6: A write with mask 00 pulses no strobe, leaves memory unchanged and leaves `req_ready_o` high in the following cycle.
- R7: A write accepted in the last hold cycle of a previous write keeps write enable low across both words, with one byte-enable pulse per word. The address changes only while both byte enables are high.
- R8: `req_ready_o` is high only when idle or in the last hold cycle of a write, and `rsp_valid_o` lasts one cycle.
- R9: Under mixed random reads and writes with random masks, every read returns the data a word-level model with byte masking predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_mask_i | input | 2 | Lane select, bit 1 upper, bit 0 lower |
| rsp_valid_o | output | 1 | Read data valid pulse |
| rsp_rdata_o | output | 16 | Read data, unselected lanes zero |
| mem_addr_o | output | 17 | RAM address |
| mem_ce_no | output | 1 | RAM chip enable, active low |
| mem_oe_no | output | 1 | RAM output enable, active low |
| mem_we_no | output | 1 | RAM write enable, active low |
| mem_be_no | output | 2 | RAM byte enables, bit 1 upper, active low |
| mem_dq_o | output | 16 | Data driven toward RAM |
| mem_dq_oe_o | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | 16 | Data seen on the RAM pins |

## Verification
Read data is due on the (RD_WAIT+1)th rising edge after the accepting edge. The bench counts edges from acceptance and checks at the falling edge just before that one that no response is present yet, then checks valid and data at the falling edge just after. Write timing is checked on the pins by counting, at falling edges, the cycles with write enable low and with a byte enable low. Burst behaviour is checked by counting write-enable rises and byte-enable pulses. A mask-00 write is checked by reading `req_ready_o` one falling edge after acceptance and by reading back the untouched word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RADDR,
    ST_RWAIT,
    ST_WSETUP,
    ST_WPULSE,
    ST_WHOLD
  } seq_st_e;

  function automatic int max_of4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2,
  parameter int WR_HOLD  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  input  logic [LANES-1:0] req_mask_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             last_o,
  output seq_st_e          state_o
);
  localparam int MAX_CNT = max_of4(RD_WAIT, WR_SETUP, WR_PULSE, WR_HOLD);
  localparam int CNT_W   = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT);

  seq_st_e          st_q, st_d;
  logic             done, load;
  logic [CNT_W-1:0] load_val;

  sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  assign ready_o  = (st_q == ST_IDLE) || ((st_q == ST_WHOLD) && done);
  assign accept_o = req_valid_i && ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (accept_o) begin
                   if (!req_write_i)           st_d = ST_RADDR;
                   else if (req_mask_i != '0)  st_d = ST_WSETUP;
                 end
      ST_RADDR:  st_d = ST_RWAIT;
      ST_RWAIT:  if (done) st_d = ST_IDLE;
      ST_WSETUP: if (done) st_d = ST_WPULSE;
      ST_WPULSE: if (done) st_d = ST_WHOLD;
      ST_WHOLD:  if (done) begin
                   if (!accept_o)              st_d = ST_IDLE;
                   else if (!req_write_i)      st_d = ST_RADDR;
                   else if (req_mask_i != '0)  st_d = ST_WSETUP;
                   else                        st_d = ST_IDLE;
                 end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    load = (st_d != st_q);
    unique case (st_d)
      ST_RWAIT:  load_val = CNT_W'(RD_WAIT - 1);
      ST_WSETUP: load_val = CNT_W'(WR_SETUP - 1);
      ST_WPULSE: load_val = CNT_W'(WR_PULSE - 1);
      ST_WHOLD:  load_val = CNT_W'(WR_HOLD - 1);
      default:   load_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign last_o  = done;
  assign state_o = st_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int RD_WAIT  = 2,
  parameter int WR_SETUP = 1,
  parameter int WR_PULSE = 2,
  parameter int WR_HOLD  = 1,
  localparam int LANES   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  seq_st_e           st;
  logic              accept, last;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, lane_bits;
  logic [LANES-1:0]  mask_q;
  logic              rsp_q;

  sram_lane_seq #(
    .LANES(LANES), .RD_WAIT(RD_WAIT), .WR_SETUP(WR_SETUP),
    .WR_PULSE(WR_PULSE), .WR_HOLD(WR_HOLD)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_mask_i  (req_mask_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .last_o      (last),
    .state_o     (st)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_bits[8*l +: 8] = {8{mask_q[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      mask_q  <= req_mask_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= (st == ST_RWAIT) && last;
      if ((st == ST_RWAIT) && last) rdata_q <= mem_dq_i & lane_bits;
    end
  end

  logic in_rd, in_wr;
  assign in_rd = (st == ST_RADDR) || (st == ST_RWAIT);
  assign in_wr = (st == ST_WSETUP) || (st == ST_WPULSE) || (st == ST_WHOLD);

  assign mem_addr_o  = addr_q;
  assign mem_ce_no   = !(in_rd || in_wr);
  assign mem_oe_no   = (st != ST_RWAIT);
  assign mem_we_no   = !in_wr;
  assign mem_be_no   = (in_rd || (st == ST_WPULSE)) ? ~mask_q : '1;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = in_wr;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_lane_chk.sv
module sram_lane_chk #(
  parameter int ADDR_W = 17,
  parameter int LANES  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_n_i,
  input logic              oe_n_i,
  input logic              we_n_i,
  input logic [LANES-1:0]  be_n_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              dq_oe_i,
  input logic              rsp_valid_i
);
  assert_oe_we_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_i && !we_n_i));

  assert_no_drive_on_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_i |-> !dq_oe_i);

  assert_oe_after_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_i) |-> $past(!dq_oe_i && we_n_i));

  assert_ce_covers_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_n_i || !we_n_i) |-> !ce_n_i);

  assert_we_drives_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_i |-> dq_oe_i);

  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_n_i != '1 && !ce_n_i) |=> (be_n_i == '1 || $stable(addr_i)));

  assert_rsp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_i |=> !rsp_valid_i);
endmodule

bind sram_lane_ctrl sram_lane_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ce_n_i      (mem_ce_no),
  .oe_n_i      (mem_oe_no),
  .we_n_i      (mem_we_no),
  .be_n_i      (mem_be_no),
  .addr_i      (mem_addr_o),
  .dq_oe_i     (mem_dq_oe_o),
  .rsp_valid_i (rsp_valid_o)
);

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;
  localparam int RD = 2, WS = 1, WP = 2, WH = 1;

  logic        clk = 0, rst_n = 0;
  logic        valid = 0, write = 0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  mask = '0;
  logic        ready, rsp_valid, ce_n, oe_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o, dq_i;
  logic [16:0] maddr;
  logic [1:0]  be_n;

  int total = 0, bad = 0;
  int we_low = 0, be_low = 0, we_rise = 0, be_pulse = 0, viol = 0;
  logic we_prev = 1, be_prev_any = 0;
  logic [16:0] addr_prev = '0;
  logic [15:0] model_out = '1;
  logic [15:0] mdl [int];
  logic [15:0] refm [int];

  always #10 clk = ~clk;

  sram_lane_ctrl #(.RD_WAIT(RD), .WR_SETUP(WS), .WR_PULSE(WP), .WR_HOLD(WH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata), .req_mask_i(mask),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rdata), .mem_addr_o(maddr),
    .mem_ce_no(ce_n), .mem_oe_no(oe_n), .mem_we_no(we_n), .mem_be_no(be_n),
    .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i));

  assign dq_i = dq_oe ? dq_o : model_out;

  function automatic logic [15:0] lanes(logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  function automatic logic [15:0] rd_mdl(int a);
    return mdl.exists(a) ? mdl[a] : 16'h0;
  endfunction

  function automatic logic [15:0] rd_ref(int a);
    return refm.exists(a) ? refm[a] : 16'h0;
  endfunction

  // memory model and pin monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [15:0] w;
      if (!oe_n && !we_n) viol++;
      if (!oe_n && dq_oe) viol++;
      if ($fell(oe_n) && !we_prev) viol++;
      if (be_n != 2'b11 && be_prev_any && !ce_n && maddr != addr_prev) viol++;
      if (!ce_n && !we_n && be_n != 2'b11) begin
        if (!dq_oe) viol++;
        w = rd_mdl(int'(maddr));
        if (!be_n[1]) w[15:8] = dq_o[15:8];
        if (!be_n[0]) w[7:0]  = dq_o[7:0];
        mdl[int'(maddr)] = w;
      end
      if (!we_n) we_low++;
      if (!we_n && be_n != 2'b11) be_low++;
      if (!we_prev && we_n) we_rise++;
      if (!we_n && !be_prev_any && be_n != 2'b11) be_pulse++;
      w = rd_mdl(int'(maddr));
      model_out <= {(!ce_n && !be_n[1]) ? w[15:8] : 8'hFF,
                    (!ce_n && !be_n[0]) ? w[7:0]  : 8'hFF};
      we_prev     = we_n;
      be_prev_any = (be_n != 2'b11);
      addr_prev   = maddr;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic clr_cnt();
    we_low = 0; be_low = 0; we_rise = 0; be_pulse = 0;
  endtask

  task automatic do_write(logic [16:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk);
    valid = 1; write = 1; addr = a; wdata = d; mask = m;
    while (!ready) @(negedge clk);
    @(posedge clk);
    refm[int'(a)] = (rd_ref(int'(a)) & ~lanes(m)) | (d & lanes(m));
    @(negedge clk);
    valid = 0;
  endtask

  task automatic do_read(logic [16:0] a, logic [1:0] m, string req);
    logic [15:0] exp;
    @(negedge clk);
    valid = 1; write = 0; addr = a; mask = m;
    while (!ready) @(negedge clk);
    @(posedge clk);
    exp = rd_ref(int'(a)) & lanes(m);
    @(negedge clk);
    valid = 0;
    repeat (RD) @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R3 early", 32'(rsp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid, "R3 valid", 32'(rsp_valid), 1);
    chk(rdata == exp, req, 32'(rdata), 32'(exp));
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk({ce_n, oe_n, we_n, be_n} == 5'b11111, "R1 strobes", 32'({ce_n, oe_n, we_n, be_n}), 32'h1F);
    chk(!dq_oe, "R1 bus", 32'(dq_oe), 0);
    chk(ready && !rsp_valid, "R1 ready", 32'({ready, rsp_valid}), 32'h2);

    // R2 single write timing
    clr_cnt();
    do_write(17'h00010, 16'hA5C3, 2'b11);
    settle();
    chk(we_low == WS + WP + WH, "R2 we_low", 32'(we_low), 32'(WS + WP + WH));
    chk(be_low == WP, "R2 be_low", 32'(be_low), 32'(WP));
    chk(ce_n && we_n && !dq_oe && ready, "R5 idle after write", 32'({ce_n, we_n, dq_oe}), 32'h6);
    do_read(17'h00010, 2'b11, "R3 full read");

    // R2 masked writes, R3 masked reads
    do_write(17'h00020, 16'h1234, 2'b11);
    do_write(17'h00020, 16'hBBxx & 16'hFF00 | 16'h0011, 2'b10);
    do_write(17'h00020, 16'hEE77, 2'b01);
    do_read(17'h00020, 2'b11, "R2 lane merge");
    do_read(17'h00020, 2'b10, "R3 upper only");
    do_read(17'h00020, 2'b01, "R3 lower only");
    do_write(17'h1FFFF, 16'hCAFE, 2'b11);
    do_read(17'h1FFFF, 2'b11, "R2 top address");

    // R6 empty mask
    settle();
    clr_cnt();
    @(negedge clk);
    valid = 1; write = 1; addr = 17'h00010; wdata = 16'h0000; mask = 2'b00;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    chk(ready, "R6 ready", 32'(ready), 1);
    settle();
    chk(we_low == 0 && be_low == 0, "R6 no strobe", 32'(we_low), 0);
    do_read(17'h00010, 2'b11, "R6 unchanged");

    // R7 burst of four writes
    settle();
    clr_cnt();
    for (int i = 0; i < 4; i++) do_write(17'h00100 + 17'(i), 16'h4000 + 16'(i * 16'h0111), 2'b11);
    settle();
    chk(we_rise == 1, "R7 we held", 32'(we_rise), 1);
    chk(be_pulse == 4, "R7 be pulses", 32'(be_pulse), 4);
    for (int i = 0; i < 4; i++) do_read(17'h00100 + 17'(i), 2'b11, "R7 burst data");

    // R8 ready low during access
    @(negedge clk);
    valid = 1; write = 0; addr = 17'h00100; mask = 2'b11;
    @(posedge clk);
    @(negedge clk);
    valid = 0;
    chk(!ready, "R8 busy", 32'(ready), 0);
    repeat (RD + 3) @(negedge clk);

    // R9 random traffic
    for (int n = 0; n < 400; n++) begin
      logic [16:0] a;
      a = 17'h00200 + 17'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 1)
        do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
      else
        do_read(a, 2'($urandom_range(0, 3)), "R9 random");
    end

    settle();
    chk(viol == 0, "R4 model order", 32'(viol), 0);
    chk(ce_n && oe_n && we_n && ready, "R1 final idle", 32'({ce_n, oe_n, we_n, ready}), 32'hF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule